// File: doc/BRIEF.md
# Supply-Good Qualifier with Reverse-Voltage Masking

This block decides when a motor supply rail may be declared good and when the downstream driver may be switched on. It compares a digitized rail-voltage code against a programmed undervoltage reference scaled by a selectable margin. It requires the forward input to be present and the reverse-voltage code to stay under its threshold. It then waits for this combined candidate condition to persist for a programmable number of milliseconds before raising the good flag. Once the good flag has been held for a fixed minimum time, the driver enable follows.

An active fault pulls the good flag (and with it the driver enable) low in the same cycle. The fault also restarts qualification. While the forward input is absent and the reverse code is at or above its threshold, the block counts the milliseconds spent in that masked state. The counter saturates at its maximum and returns to zero once the rail is declared good. A free-running prescaler derives the millisecond tick from the system clock.

Top module: `pwrgood_qual`

## Requirements
- R1: The voltage test passes when `vout_code_i*40 >= uvlo_ref_i*N`, where N is 44 for `margin_sel_i`=0 (1.10), 45 for 1 (1.125), and 46 for 2 or 3 (1.15). The test is exact, including at equality.
- R2: The candidate condition also requires `fwd_ok_i`=1, `vrev_code_i < vrev_th_i` and `fault_i`=0.
- R3: The debounce length in ms is `dbnc_ms_i` clamped to the range 5..20. A debounce counter counts ms ticks while the candidate holds and stops at that length. `pg_o` rises on the clock edge after the counter has reached the length with the candidate still true.
- R4: Any cycle with the candidate false clears the debounce counter to zero. The same cycle's edge also clears the registered good state, so qualification restarts from zero.
- R5: While `fault_i`=1, `pg_o` and `drv_en_o` are 0 in that same cycle.
- R6: A hold counter counts ms ticks while `pg_o`=1 and stops at HOLD_MS. `drv_en_o` rises on the edge after the hold counter has reached HOLD_MS with `pg_o` still 1, and is never 1 while `pg_o` is 0.
- R7: While `pg_o`=0, `fwd_ok_i`=0 and `vrev_code_i >= vrev_th_i`, `mask_ms_o` increments by one on each ms tick. It saturates at all-ones.
- R8: `mask_ms_o` is cleared on every edge where `pg_o`=1.
- R9: After reset, `pg_o`, `drv_en_o` and `mask_ms_o` are all zero.
- R10: The ms tick occurs on every TICKS_PER_MS-th clock, counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vout_code_i | input | VW | Digitized rail voltage |
| uvlo_ref_i | input | VW | Downstream undervoltage reference code |
| margin_sel_i | input | 2 | Margin select (0:1.10, 1:1.125, 2/3:1.15) |
| fwd_ok_i | input | 1 | Forward input present |
| vrev_code_i | input | VW | Digitized reverse voltage |
| vrev_th_i | input | VW | Reverse-voltage threshold |
| fault_i | input | 1 | Active fault |
| dbnc_ms_i | input | 5 | Debounce length in ms (clamped 5..20) |
| pg_o | output | 1 | Qualified supply-good |
| drv_en_o | output | 1 | Driver enable |
| mask_ms_o | output | MASK_W | Milliseconds spent in the reverse-masked state |

## Verification
A fault can arrive in the very cycle in which debounce completion would raise the good flag. The bench provokes this by watching its own model's debounce count and raising the fault exactly when that count reaches the programmed length. The expectation is that the fault wins: the good flag stays low, and qualification restarts from zero after the fault clears. The bench also exercises a second pair of events. The masked-duration counter sits saturated when the good flag finally rises, and it must return to zero rather than wrap or hold.

// File: rtl/pgq_pkg.sv
package pgq_pkg;
   localparam int unsigned MARGIN_DEN = 40;
   localparam int unsigned DBNC_MIN   = 5;
   localparam int unsigned DBNC_MAX   = 20;

   typedef enum logic [1:0] {
      MG_110  = 2'd0,
      MG_1125 = 2'd1,
      MG_115  = 2'd2,
      MG_115X = 2'd3
   } margin_e;

   function automatic logic [5:0] margin_num(input logic [1:0] sel);
      case (margin_e'(sel))
         MG_110:  return 6'd44;
         MG_1125: return 6'd45;
         default: return 6'd46;
      endcase
   endfunction

   function automatic logic [4:0] dbnc_clamp(input logic [4:0] code);
      if (code < 5'(DBNC_MIN)) return 5'(DBNC_MIN);
      if (code > 5'(DBNC_MAX)) return 5'(DBNC_MAX);
      return code;
   endfunction
endpackage

// File: rtl/pgq_ms_tick.sv
module pgq_ms_tick #(
   parameter int unsigned TICKS_PER_MS = 200000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   generate
      if (TICKS_PER_MS < 1) begin : g_bad
         $error("TICKS_PER_MS must be at least 1");
      end
      if (TICKS_PER_MS == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned TW = $clog2(TICKS_PER_MS);
         localparam logic [TW-1:0] LAST = TW'(TICKS_PER_MS - 1);
         logic [TW-1:0] cnt_q;
         assign tick_o = (cnt_q == LAST);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     cnt_q <= '0;
            else if (tick_o) cnt_q <= '0;
            else             cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pgq_window_cmp.sv
module pgq_window_cmp
   import pgq_pkg::*;
#(
   parameter int unsigned VW = 12
) (
   input  logic [VW-1:0] vout_code_i,
   input  logic [VW-1:0] uvlo_ref_i,
   input  logic [1:0]    margin_sel_i,
   input  logic          fwd_ok_i,
   input  logic [VW-1:0] vrev_code_i,
   input  logic [VW-1:0] vrev_th_i,
   input  logic          fault_i,
   output logic          cand_o,
   output logic          masked_o
);
   localparam int unsigned PW = VW + 6;

   logic [PW-1:0] lhs, rhs;
   logic          rev_low;

   always_comb begin
      lhs     = PW'(vout_code_i) * PW'(MARGIN_DEN);
      rhs     = PW'(uvlo_ref_i) * PW'(margin_num(margin_sel_i));
      rev_low = (vrev_code_i < vrev_th_i);
      cand_o  = (lhs >= rhs) && fwd_ok_i && rev_low && !fault_i;
      masked_o = !fwd_ok_i && !rev_low;
   end
endmodule

// File: rtl/pgq_stage_timer.sv
module pgq_stage_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          en_i,
   input  logic [CW-1:0] limit_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= en_i && (cnt_q >= limit_i);
         if (!en_i)                          cnt_q <= '0;
         else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/pwrgood_qual.sv
module pwrgood_qual
   import pgq_pkg::*;
#(
   parameter int unsigned VW           = 12,
   parameter int unsigned TICKS_PER_MS = 200000,
   parameter int unsigned HOLD_MS      = 10,
   parameter int unsigned MASK_W       = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [VW-1:0]     vout_code_i,
   input  logic [VW-1:0]     uvlo_ref_i,
   input  logic [1:0]        margin_sel_i,
   input  logic              fwd_ok_i,
   input  logic [VW-1:0]     vrev_code_i,
   input  logic [VW-1:0]     vrev_th_i,
   input  logic              fault_i,
   input  logic [4:0]        dbnc_ms_i,
   output logic              pg_o,
   output logic              drv_en_o,
   output logic [MASK_W-1:0] mask_ms_o
);
   localparam int unsigned HW = $clog2(HOLD_MS + 1);

   generate
      if (VW < 2 || VW > 24) begin : g_bad_vw
         $error("VW out of supported range 2..24");
      end
      if (HOLD_MS < 1) begin : g_bad_hold
         $error("HOLD_MS must be at least 1");
      end
      if (MASK_W < 2) begin : g_bad_mask
         $error("MASK_W must be at least 2");
      end
   endgenerate

   logic tick, cand, masked, pg_q, drv_q;
   logic [MASK_W-1:0] mask_q;

   pgq_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   pgq_window_cmp #(.VW(VW)) u_cmp (
      .vout_code_i  (vout_code_i),
      .uvlo_ref_i   (uvlo_ref_i),
      .margin_sel_i (margin_sel_i),
      .fwd_ok_i     (fwd_ok_i),
      .vrev_code_i  (vrev_code_i),
      .vrev_th_i    (vrev_th_i),
      .fault_i      (fault_i),
      .cand_o       (cand),
      .masked_o     (masked)
   );

   pgq_stage_timer #(.CW(5)) u_dbnc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .en_i    (cand),
      .limit_i (dbnc_clamp(dbnc_ms_i)),
      .done_o  (pg_q)
   );

   assign pg_o = pg_q && !fault_i;

   pgq_stage_timer #(.CW(HW)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .en_i    (pg_o),
      .limit_i (HW'(HOLD_MS)),
      .done_o  (drv_q)
   );

   assign drv_en_o = drv_q && pg_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mask_q <= '0;
      else if (pg_o)                          mask_q <= '0;
      else if (masked && tick && !(&mask_q))  mask_q <= mask_q + 1'b1;
   end

   assign mask_ms_o = mask_q;
endmodule

// File: rtl/pgq_checker.sv
module pgq_checker #(
   parameter int unsigned VW     = 12,
   parameter int unsigned MASK_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fwd_ok_i,
   input logic [VW-1:0]     vrev_code_i,
   input logic [VW-1:0]     vrev_th_i,
   input logic              fault_i,
   input logic              pg_o,
   input logic              drv_en_o,
   input logic [MASK_W-1:0] mask_ms_o
);
   p_pg_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pg_o) |-> $past(fwd_ok_i) && ($past(vrev_code_i) < $past(vrev_th_i)));

   p_fault_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |=> !pg_o);

   p_drv_after_pg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drv_en_o) |-> $past(pg_o));

   p_mask_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&mask_ms_o) && !pg_o |=> (&mask_ms_o));

   p_mask_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (mask_ms_o == $past(mask_ms_o)) || (mask_ms_o == $past(mask_ms_o) + 1'b1)
               || (mask_ms_o == '0));

   p_mask_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pg_o |=> mask_ms_o == '0);
endmodule

bind pwrgood_qual pgq_checker #(.VW(VW), .MASK_W(MASK_W)) u_pgq_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .fwd_ok_i    (fwd_ok_i),
   .vrev_code_i (vrev_code_i),
   .vrev_th_i   (vrev_th_i),
   .fault_i     (fault_i),
   .pg_o        (pg_o),
   .drv_en_o    (drv_en_o),
   .mask_ms_o   (mask_ms_o)
);

// File: tb/pwrgood_qual_test.sv
`timescale 1ns/1ps
module pwrgood_qual_test;
   localparam int VW = 10, TPM = 4, HOLD = 3, MW = 4;
   localparam int MMAX = (1 << MW) - 1;

   logic clk = 0, rst_ni = 0;
   logic [VW-1:0] vout = 0, uref = 200, vrev = 0, vth = 50;
   logic [1:0] msel = 0;
   logic fwd = 0, fault = 0;
   logic [4:0] dbnc = 5;
   logic pg, drv;
   logic [MW-1:0] mask;

   always #2.5 clk = ~clk;

   pwrgood_qual #(.VW(VW), .TICKS_PER_MS(TPM), .HOLD_MS(HOLD), .MASK_W(MW)) uut (
      .clk_i(clk), .rst_ni(rst_ni), .vout_code_i(vout), .uvlo_ref_i(uref),
      .margin_sel_i(msel), .fwd_ok_i(fwd), .vrev_code_i(vrev), .vrev_th_i(vth),
      .fault_i(fault), .dbnc_ms_i(dbnc), .pg_o(pg), .drv_en_o(drv), .mask_ms_o(mask));

   int checks = 0, errors = 0, cyc = 0;
   string cur_req = "R9";

   // behavioural reference model
   int m_tc, m_db, m_hold, m_mask;
   bit m_pgq, m_drvq;

   function automatic int num_of(input int s);
      return (s == 0) ? 44 : (s == 1) ? 45 : 46;
   endfunction
   function automatic int lim_of(input int c);
      return (c < 5) ? 5 : (c > 20) ? 20 : c;
   endfunction
   function automatic bit m_cand();
      return fwd && (vrev < vth) && !fault &&
             (int'(vout) * 40 >= int'(uref) * num_of(int'(msel)));
   endfunction
   function automatic bit m_pg();
      return m_pgq && !fault;
   endfunction
   function automatic bit m_drv();
      return m_drvq && m_pg();
   endfunction

   always @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         m_tc = 0; m_db = 0; m_hold = 0; m_mask = 0; m_pgq = 0; m_drvq = 0;
      end else begin
         bit tk, c, p, msk;
         int lim;
         tk  = (m_tc == TPM - 1);
         c   = m_cand();
         p   = m_pg();
         lim = lim_of(int'(dbnc));
         msk = !fwd && (vrev >= vth);
         m_pgq  = c && (m_db >= lim);
         m_drvq = p && (m_hold >= HOLD);
         if (!c) m_db = 0; else if (tk && m_db < lim) m_db++;
         if (!p) m_hold = 0; else if (tk && m_hold < HOLD) m_hold++;
         if (p) m_mask = 0; else if (msk && tk && m_mask < MMAX) m_mask++;
         m_tc = tk ? 0 : m_tc + 1;
      end
   end

   always @(negedge clk) begin
      cyc++;
      checks++;
      if (pg !== m_pg() || drv !== m_drv() || mask !== MW'(m_mask)) begin
         errors++;
         $display("FAIL %s cyc %0d: pg/drv/mask actual %b/%b/%0d expected %b/%b/%0d",
                  cur_req, cyc, pg, drv, mask, m_pg(), m_drv(), m_mask);
      end
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic expect_pg(input string req, input bit exp_pg);
      checks++;
      if (pg !== exp_pg) begin
         errors++;
         $display("FAIL %s directed: pg actual %b expected %b", req, pg, exp_pg);
      end
   endtask

   initial begin
      step(3);
      expect_pg("R9", 0);
      rst_ni = 1;
      // R10: tick spacing drives every timing below; model counts from reset release
      cur_req = "R1"; fwd = 1; msel = 0; vout = 220; dbnc = 5;   // 220*40 == 200*44
      step(40); expect_pg("R1", 1);
      step(20);
      vout = 219; step(4); expect_pg("R1", 0);
      msel = 1; vout = 224; step(40); expect_pg("R1", 0);
      vout = 225; step(40); expect_pg("R1", 1);
      msel = 2; vout = 229; step(10);
      vout = 230; step(40); expect_pg("R1", 1);
      msel = 3; vout = 229; step(10); vout = 230; step(40);
      cur_req = "R2"; fwd = 0; step(5); expect_pg("R2", 0);
      fwd = 1; step(40); vrev = 50; step(5); expect_pg("R2", 0);
      vrev = 49; step(40); expect_pg("R2", 1);
      cur_req = "R3"; vrev = 0; fwd = 0; step(3);
      dbnc = 0; fwd = 1; step(60);
      fwd = 0; step(3); dbnc = 12; fwd = 1; step(70);
      fwd = 0; step(3); dbnc = 31; fwd = 1; step(100);
      cur_req = "R4"; fwd = 0; step(2); dbnc = 8; fwd = 1; step(20);
      fwd = 0; step(1); fwd = 1; step(20); fwd = 0; step(1); fwd = 1; step(50);
      cur_req = "R5"; fault = 1; step(1); expect_pg("R5", 0);
      fault = 0; step(3);
      // fault lands on the cycle debounce completes
      while (!(m_db == lim_of(int'(dbnc)) && !m_pgq)) step(1);
      fault = 1; step(2); expect_pg("R5", 0);
      fault = 0; step(50);
      cur_req = "R6"; step(30); fault = 1; step(2); fault = 0; step(60);
      cur_req = "R7"; fwd = 0; vrev = 60; step(100);
      fwd = 1; step(10); fwd = 0; step(20);
      cur_req = "R8"; vrev = 0; fwd = 1; step(60);
      cur_req = "R7"; fwd = 0; vrev = 70; step(20);
      vrev = 10; step(10);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule